// File: doc/BRIEF.md
# Warp Fence Completion Tracker

This block sits in a GPU core next to the store path. It orders memory by time stamps, with no coherence messages. The shared cache never holds a store back. Instead, every store response carries a global write completion time. The tracker keeps the largest such time for each warp. It also counts the stores each warp has issued that have not yet had a response.

When a warp reaches a memory fence, the issue logic raises a request naming that warp. It holds the request until it sees a grant. The tracker arms that warp's fence and releases it once the shared global time is strictly past the warp's recorded completion time and the warp has no stores in flight. This ensures that data written before the fence is visible to every core before any store after the fence (for example a flag) leaves the core. The time stamps are unsigned and are assumed not to wrap within one run.

Top module: `warp_fence_tracker`

## Requirements
- R1: After a synchronous active-low reset, `fence_gnt`, `fence_stall` and every bit of `fence_release` are 0. Every recorded completion time is zero and every in-flight count is zero.
- R2: A store response for warp w sets w's recorded time to the larger of its current value and `st_resp_time`, taking effect from the next clock edge.
- R3: A store response carrying a time below warp w's recorded time leaves the recorded time unchanged.
- R4: An armed fence for warp w is released only when `global_time` is strictly greater than w's recorded time. Equality keeps it held.
- R5: An armed fence for warp w stays held while w has any store that was issued and has not yet had a response, whatever `global_time` is.
- R6: A store issue for warp w raises w's in-flight count by one. A store response lowers it by one. An issue and a response for the same warp in the same cycle leave the count unchanged.
- R7: A store response and a fence request for the same warp in the same cycle are both accepted. The fence is then judged against the merged recorded time.
- R8: `fence_release` bit w (bit index equals warp ID) is high for exactly one cycle per armed fence and then returns to 0 with the fence disarmed.
- R9: A fence is armed at the first clock edge at which its request is seen, so the grant comes at the earliest in the following cycle. `fence_gnt` is high when the requested warp's release bit is high. `fence_stall` equals `fence_req` and not `fence_gnt`.
- R10: Warps are independent. An armed fence of a warp other than `fence_warp` can release, which raises its own `fence_release` bit but not `fence_gnt`.
- R11: Right after reset, a fence with `global_time` of 1 or more and no stores in flight is released in the cycle after it is armed. With `global_time` of 0 it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| st_issue_vld | input | 1 | A store leaves the core this cycle |
| st_issue_warp | input | 3 | Warp that issued the store |
| st_resp_vld | input | 1 | A store response arrives this cycle |
| st_resp_warp | input | 3 | Warp the response belongs to |
| st_resp_time | input | 16 | Global write completion time carried by the response |
| fence_req | input | 1 | Fence request, held until granted |
| fence_warp | input | 3 | Warp executing the fence |
| global_time | input | 16 | Shared global time |
| fence_gnt | output | 1 | Requested warp's fence is released this cycle |
| fence_stall | output | 1 | Fence requested but not yet granted |
| fence_release | output | 8 | Per-warp one-cycle release pulses |

## Verification
The recorded times and in-flight counts are updated at the edge that samples a store event. They are first used in the cycle after that edge. A fence request is armed at its first edge, and its release, grant and stall are combinational in each later cycle from the armed state and the current `global_time`. The bench therefore drives each stimulus just after a falling edge. It compares outputs one nanosecond before the next rising edge, expecting every stored effect one cycle after the event that caused it. Recorded times are never read directly. They are inferred from the exact `global_time` at which a fence releases, with equality and one step above tried on either side.

// File: rtl/wft_pkg.sv
// Package: shared types of the warp fence completion tracker.
// Assumes nothing beyond IEEE 1800-2017 enums.
package wft_pkg;

    // Action applied to a warp's in-flight store counter in one cycle
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_INC  = 2'd1,
        CNT_DEC  = 2'd2
    } cnt_op_e;

    // Fence state of one warp
    typedef enum logic {
        FS_IDLE  = 1'b0,
        FS_ARMED = 1'b1
    } fence_st_e;

endpackage

// File: rtl/wft_warp_entry.sv
// Module: one warp's slot in the tracker. Holds the largest completion time
// returned for the warp and a count of its stores still awaiting a response,
// and flags when a fence for the warp could complete.
// Assumes: a response never arrives for a warp with a zero count and the
// count never overflows; time stamps do not wrap.
module wft_warp_entry
    import wft_pkg::*;
#(
    parameter int TS_W    = 16,
    parameter int CNT_W   = 6,
    parameter int WID_W   = 3,
    parameter int WARP_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_vld,
    input  logic [WID_W-1:0] issue_warp,
    input  logic             resp_vld,
    input  logic [WID_W-1:0] resp_warp,
    input  logic [TS_W-1:0]  resp_time,
    input  logic [TS_W-1:0]  global_time,
    output logic [TS_W-1:0]  ent_time,
    output logic [CNT_W-1:0] ent_cnt,
    output logic             ready
);

    localparam logic [WID_W-1:0] MY_ID = WID_W'(WARP_ID);

    logic             issue_hit;
    logic             resp_hit;
    logic [TS_W-1:0]  time_q;
    logic [TS_W-1:0]  time_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    cnt_op_e          cnt_op;

    // Decode whether this cycle's store events belong to this warp
    always_comb begin
        issue_hit = issue_vld && (issue_warp == MY_ID);
        resp_hit  = resp_vld  && (resp_warp  == MY_ID);
    end

    // Keep the maximum completion time seen for this warp
    always_comb begin
        time_d = time_q;
        if (resp_hit && (resp_time > time_q)) begin
            time_d = resp_time;
        end
    end

    // Choose the counter action; simultaneous issue and response cancel out
    always_comb begin
        cnt_op = CNT_HOLD;
        if (issue_hit && !resp_hit) begin
            cnt_op = CNT_INC;
        end else if (resp_hit && !issue_hit && (cnt_q != '0)) begin
            cnt_op = CNT_DEC;
        end
    end

    // Apply the counter action
    always_comb begin
        unique case (cnt_op)
            CNT_INC: cnt_d = cnt_q + CNT_W'(1);
            CNT_DEC: cnt_d = cnt_q - CNT_W'(1);
            default: cnt_d = cnt_q;
        endcase
    end

    // State registers of the slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= '0;
            cnt_q  <= '0;
        end else begin
            time_q <= time_d;
            cnt_q  <= cnt_d;
        end
    end

    // A fence may complete once global time is past the slot and none in flight
    always_comb begin
        ready    = (global_time > time_q) && (cnt_q == '0);
        ent_time = time_q;
        ent_cnt  = cnt_q;
    end

endmodule

// File: rtl/wft_fence_ctrl.sv
// Module: per-warp fence arming and release, plus the request/grant
// handshake toward the issue logic. A fence is armed at the first edge its
// request is seen and released when the warp's slot reports ready.
// Assumes: the requester holds fence_req and fence_warp until fence_gnt.
module wft_fence_ctrl
    import wft_pkg::*;
#(
    parameter int NUM_WARPS = 8,
    parameter int WID_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fence_req,
    input  logic [WID_W-1:0]     fence_warp,
    input  logic [NUM_WARPS-1:0] ready_vec,
    output logic [NUM_WARPS-1:0] release_vec,
    output logic                 fence_gnt,
    output logic                 fence_stall
);

    fence_st_e            st_q [NUM_WARPS];
    logic [NUM_WARPS-1:0] armed;
    logic [NUM_WARPS-1:0] req_hit;

    // Per-warp fence state machine
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        // Decode the request for this warp and expose the armed flag
        always_comb begin
            req_hit[w] = fence_req && (fence_warp == WID_W'(w));
            armed[w]   = (st_q[w] == FS_ARMED);
        end

        // Arm on request, disarm on release; release takes precedence
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[w] <= FS_IDLE;
            end else if (release_vec[w]) begin
                st_q[w] <= FS_IDLE;
            end else if (req_hit[w]) begin
                st_q[w] <= FS_ARMED;
            end
        end
    end

    // Release pulses, grant to the requested warp, and stall to the issuer
    always_comb begin
        release_vec = armed & ready_vec;
        fence_gnt   = fence_req && release_vec[fence_warp];
        fence_stall = fence_req && !fence_gnt;
    end

endmodule

// File: rtl/warp_fence_tracker.sv
// Module: top of the warp fence completion tracker. One slot per warp records
// the latest global write completion time and the stores in flight; the fence
// controller holds a fencing warp until global time has passed its slot.
// Assumes: NUM_WARPS is a power of two of at least 2; stores are never
// stalled downstream, so ordering is enforced only here.
module warp_fence_tracker #(
    parameter int NUM_WARPS = 8,
    parameter int TS_W      = 16,
    parameter int CNT_W     = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         st_issue_vld,
    input  logic [$clog2(NUM_WARPS)-1:0] st_issue_warp,
    input  logic                         st_resp_vld,
    input  logic [$clog2(NUM_WARPS)-1:0] st_resp_warp,
    input  logic [TS_W-1:0]              st_resp_time,
    input  logic                         fence_req,
    input  logic [$clog2(NUM_WARPS)-1:0] fence_warp,
    input  logic [TS_W-1:0]              global_time,
    output logic                         fence_gnt,
    output logic                         fence_stall,
    output logic [NUM_WARPS-1:0]         fence_release
);

    localparam int WID_W = $clog2(NUM_WARPS);

    logic [NUM_WARPS-1:0]            ready_vec;
    logic [NUM_WARPS-1:0][TS_W-1:0]  ent_time;
    logic [NUM_WARPS-1:0][CNT_W-1:0] ent_cnt;

    // One tracking slot per warp
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
        wft_warp_entry #(
            .TS_W    (TS_W),
            .CNT_W   (CNT_W),
            .WID_W   (WID_W),
            .WARP_ID (w)
        ) u_entry (
            .clk         (clk),
            .rst_n       (rst_n),
            .issue_vld   (st_issue_vld),
            .issue_warp  (st_issue_warp),
            .resp_vld    (st_resp_vld),
            .resp_warp   (st_resp_warp),
            .resp_time   (st_resp_time),
            .global_time (global_time),
            .ent_time    (ent_time[w]),
            .ent_cnt     (ent_cnt[w]),
            .ready       (ready_vec[w])
        );
    end

    wft_fence_ctrl #(
        .NUM_WARPS (NUM_WARPS),
        .WID_W     (WID_W)
    ) u_fence (
        .clk         (clk),
        .rst_n       (rst_n),
        .fence_req   (fence_req),
        .fence_warp  (fence_warp),
        .ready_vec   (ready_vec),
        .release_vec (fence_release),
        .fence_gnt   (fence_gnt),
        .fence_stall (fence_stall)
    );

endmodule

// File: rtl/wft_checker.sv
// Module: assertion checker for warp_fence_tracker, attached by bind.
// Assumes: it observes the slot state the top exposes between its submodules.
module wft_checker #(
    parameter int NUM_WARPS = 8,
    parameter int TS_W      = 16,
    parameter int CNT_W     = 6
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            st_issue_vld,
    input logic [$clog2(NUM_WARPS)-1:0]    st_issue_warp,
    input logic                            st_resp_vld,
    input logic [$clog2(NUM_WARPS)-1:0]    st_resp_warp,
    input logic [TS_W-1:0]                 st_resp_time,
    input logic                            fence_req,
    input logic [TS_W-1:0]                 global_time,
    input logic                            fence_gnt,
    input logic [NUM_WARPS-1:0]            fence_release,
    input logic [NUM_WARPS-1:0][TS_W-1:0]  ent_time,
    input logic [NUM_WARPS-1:0][CNT_W-1:0] ent_cnt
);

    localparam int WID_W = $clog2(NUM_WARPS);

    // A grant only follows a request that was already present a cycle earlier
    p_gnt_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fence_gnt |-> $past(fence_req));

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_chk
        // Recorded time never decreases
        p_entry_monotone_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ent_time[w] >= $past(ent_time[w]));

        // A response lifts the slot to at least its time
        p_resp_merge_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (st_resp_vld && st_resp_warp == WID_W'(w)) |=> ent_time[w] >= $past(st_resp_time));

        // Release only with global time strictly past the slot
        p_release_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
            fence_release[w] |-> global_time > ent_time[w]);

        // Release only with no stores in flight
        p_release_drained_r5: assert property (@(posedge clk) disable iff (!rst_n)
            fence_release[w] |-> ent_cnt[w] == '0);

        // Release is a single-cycle pulse
        p_release_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
            fence_release[w] |=> !fence_release[w]);

        // Counter never wraps upward
        p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ent_cnt[w] == '1 && st_issue_vld && st_issue_warp == WID_W'(w))
            |-> (st_resp_vld && st_resp_warp == WID_W'(w)));

        // No response arrives for a warp with nothing in flight
        p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (st_resp_vld && st_resp_warp == WID_W'(w) && ent_cnt[w] == '0)
            |-> (st_issue_vld && st_issue_warp == WID_W'(w)));
    end

endmodule

bind warp_fence_tracker wft_checker #(
    .NUM_WARPS (NUM_WARPS),
    .TS_W      (TS_W),
    .CNT_W     (CNT_W)
) u_wft_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .st_issue_vld  (st_issue_vld),
    .st_issue_warp (st_issue_warp),
    .st_resp_vld   (st_resp_vld),
    .st_resp_warp  (st_resp_warp),
    .st_resp_time  (st_resp_time),
    .fence_req     (fence_req),
    .global_time   (global_time),
    .fence_gnt     (fence_gnt),
    .fence_release (fence_release),
    .ent_time      (ent_time),
    .ent_cnt       (ent_cnt)
);

// File: tb/test_warp_fence_tracker.sv
// Bench: vector table walked cycle by cycle, then directed reset test.
module test_warp_fence_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_issue_vld = 1'b0;
    logic [2:0]  st_issue_warp = '0;
    logic        st_resp_vld = 1'b0;
    logic [2:0]  st_resp_warp = '0;
    logic [15:0] st_resp_time = '0;
    logic        fence_req = 1'b0;
    logic [2:0]  fence_warp = '0;
    logic [15:0] global_time = '0;
    logic        fence_gnt;
    logic        fence_stall;
    logic [7:0]  fence_release;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    warp_fence_tracker i_warp_fence_tracker (
        .clk           (clk),
        .rst_n         (rst_n),
        .st_issue_vld  (st_issue_vld),
        .st_issue_warp (st_issue_warp),
        .st_resp_vld   (st_resp_vld),
        .st_resp_warp  (st_resp_warp),
        .st_resp_time  (st_resp_time),
        .fence_req     (fence_req),
        .fence_warp    (fence_warp),
        .global_time   (global_time),
        .fence_gnt     (fence_gnt),
        .fence_stall   (fence_stall),
        .fence_release (fence_release)
    );

    typedef struct packed {
        logic        iv;
        logic [2:0]  iw;
        logic        rv;
        logic [2:0]  rw;
        logic [15:0] rt;
        logic        fr;
        logic [2:0]  fw;
        logic [15:0] gt;
        logic        eg;
        logic        es;
        logic [7:0]  er;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    // iv iw rv rw rt | fr fw gt | exp gnt stall release | requirement
    localparam vec_t VECS [NV] = '{
        '{0,0,0,0,16'd0,  0,0,16'd0,  0,0,8'h00, 4'd1},  // R1 idle after reset
        '{0,0,0,0,16'd0,  1,0,16'd0,  0,1,8'h00, 4'd9},  // R9 arming cycle stalls
        '{0,0,0,0,16'd0,  1,0,16'd0,  0,1,8'h00, 4'd4},  // R4 time equal to zero slot
        '{0,0,0,0,16'd0,  1,0,16'd1,  1,0,8'h01, 4'd11}, // R11 reset slot releases
        '{1,1,0,0,16'd0,  0,0,16'd1,  0,0,8'h00, 4'd6},  // R6 issue warp 1
        '{1,1,1,1,16'd20, 0,0,16'd2,  0,0,8'h00, 4'd6},  // R6 issue and response together
        '{0,0,1,1,16'd10, 0,0,16'd2,  0,0,8'h00, 4'd3},  // R3 smaller time
        '{0,0,0,0,16'd0,  1,1,16'd15, 0,1,8'h00, 4'd9},  // R9 arm warp 1
        '{0,0,0,0,16'd0,  1,1,16'd15, 0,1,8'h00, 4'd3},  // R3 slot kept 20
        '{0,0,0,0,16'd0,  1,1,16'd20, 0,1,8'h00, 4'd4},  // R4 equality holds
        '{0,0,0,0,16'd0,  1,1,16'd21, 1,0,8'h02, 4'd2},  // R2 released above max
        '{1,2,0,0,16'd0,  0,0,16'd21, 0,0,8'h00, 4'd5},  // R5 issue warp 2
        '{0,0,0,0,16'd0,  1,2,16'd30, 0,1,8'h00, 4'd5},  // R5 arm
        '{0,0,0,0,16'd0,  1,2,16'd30, 0,1,8'h00, 4'd5},  // R5 in flight holds
        '{0,0,1,2,16'd25, 1,2,16'd30, 0,1,8'h00, 4'd5},  // R5 response not yet counted
        '{0,0,0,0,16'd0,  1,2,16'd30, 1,0,8'h04, 4'd5},  // R5 drained releases
        '{1,3,0,0,16'd0,  0,0,16'd40, 0,0,8'h00, 4'd7},  // R7 issue warp 3
        '{0,0,1,3,16'd50, 1,3,16'd40, 0,1,8'h00, 4'd7},  // R7 response and fence together
        '{0,0,0,0,16'd0,  1,3,16'd45, 0,1,8'h00, 4'd7},  // R7 judged against 50
        '{0,0,0,0,16'd0,  1,3,16'd51, 1,0,8'h08, 4'd7},  // R7 release
        '{0,0,0,0,16'd0,  1,4,16'd51, 0,1,8'h00, 4'd10}, // R10 arm warp 4
        '{0,0,0,0,16'd0,  1,5,16'd51, 0,1,8'h10, 4'd10}, // R10 warp 4 releases, no grant
        '{0,0,0,0,16'd0,  1,5,16'd51, 1,0,8'h20, 4'd10}, // R10 warp 5 granted
        '{0,0,0,0,16'd0,  0,0,16'd51, 0,0,8'h00, 4'd8}   // R8 pulses gone
    };

    // Compare the three outputs against expectations for one requirement
    task automatic check(input logic eg, input logic es, input logic [7:0] er,
                         input int rq, input int idx);
        n_checks++;
        if (fence_gnt !== eg || fence_stall !== es || fence_release !== er) begin
            n_fail++;
            $display("FAIL R%0d step %0d: gnt/stall/release = %b/%b/%h, expected %b/%b/%h",
                     rq, idx, fence_gnt, fence_stall, fence_release, eg, es, er);
        end
    endtask

    // Drive idle inputs
    task automatic idle_inputs();
        st_issue_vld = 1'b0;
        st_resp_vld  = 1'b0;
        fence_req    = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #3 check(1'b0, 1'b0, 8'h00, 1, -1);   // R1 outputs during reset
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            st_issue_vld  = VECS[i].iv;
            st_issue_warp = VECS[i].iw;
            st_resp_vld   = VECS[i].rv;
            st_resp_warp  = VECS[i].rw;
            st_resp_time  = VECS[i].rt;
            fence_req     = VECS[i].fr;
            fence_warp    = VECS[i].fw;
            global_time   = VECS[i].gt;
            #3 check(VECS[i].eg, VECS[i].es, VECS[i].er, int'(VECS[i].req), i);
            @(negedge clk);
        end

        // Directed R1/R11: state left in warp 6, then reset clears it
        idle_inputs();
        st_issue_vld = 1'b1; st_issue_warp = 3'd6;
        @(negedge clk);
        st_resp_vld = 1'b1; st_resp_warp = 3'd6; st_resp_time = 16'd100;
        @(negedge clk);
        idle_inputs();
        st_issue_vld = 1'b1; st_issue_warp = 3'd6;
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        fence_req = 1'b1; fence_warp = 3'd6; global_time = 16'd1;
        @(negedge clk);
        #3 check(1'b0, 1'b1, 8'h00, 1, 100);  // R1 nothing armed in reset
        @(negedge clk);
        rst_n = 1'b1;
        #3 check(1'b0, 1'b1, 8'h00, 9, 101);  // R9 arming cycle
        @(negedge clk);
        #3 check(1'b1, 1'b0, 8'h40, 11, 102); // R11 time and count cleared
        @(negedge clk);
        idle_inputs();
        #3 check(1'b0, 1'b0, 8'h00, 8, 103);  // R8 pulse over

        // Directed R11: zero global time keeps a fresh slot held
        @(negedge clk);
        fence_req = 1'b1; fence_warp = 3'd7; global_time = 16'd0;
        @(negedge clk);
        #3 check(1'b0, 1'b1, 8'h00, 11, 104); // R11 held at time zero
        @(negedge clk);
        global_time = 16'd1;
        #3 check(1'b1, 1'b0, 8'h80, 11, 105); // R11 released
        @(negedge clk);
        idle_inputs();

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule